// File: doc/BRIEF.md
# Serial EEPROM Station Address Reader

This block reads a serial configuration memory that uses a three-wire clocked interface with 6-bit word addresses. It has a chip select, a shift clock and a serial data line towards the memory, and a serial data line back from it. After a single start pulse it runs a read access for each of the words 0 to 15 in ascending order. Each 16-bit word is stored little-endian into a 32-byte image, so the low byte of word n lands at byte 2n.

When the burst completes, the block picks the 6-byte station address out of image bytes 20 to 25. It presents that address on a 48-bit output together with a one-cycle done pulse. A clock divider keeps every high and low phase of the shift clock at least `HALF_CYC` system clocks long, so the memory's clock limit is met at any system clock rate.

Top module: `ee_mac_reader`

## Requirements
- R1: Each word access shifts out an 11-bit command, most significant bit first. The bits are 0, 0, 1, 1, 0, followed by the 6-bit word address a5..a0.
- R2: Chip select is low for one phase and then goes high before the first command bit. It falls only after the low phase that follows the 16th data bit. The shift clock is never high while chip select is low.
- R3: The data line towards the memory is set while the shift clock is low. It does not change in any cycle where the shift clock is high.
- R4: After the command, the data line towards the memory is 0. The block then takes 16 data bits, most significant bit first. Each bit is sampled at the end of a shift-clock high phase, and the clock is then lowered.
- R5: A burst reads word addresses 0, 1, ... 15, each exactly once and in ascending order.
- R6: Image byte 2n holds bits 7:0 of word n, and byte 2n+1 holds bits 15:8. `mac_o[47:40]` is image byte 20, and each following lower byte of `mac_o` is the next image byte, so `mac_o[7:0]` is byte 25.
- R7: Every high phase and every low phase of the shift clock lasts at least `HALF_CYC` system clocks.
- R8: `busy_o` rises in the cycle after a start is accepted while idle. It stays high until the burst completes and is low while `done_o` is high. A `start_i` pulse seen while `busy_o` is high is ignored and does not restart the burst.
- R9: `done_o` is high for exactly one cycle per burst. `mac_o` changes only in a cycle where `done_o` is high, and otherwise holds its value, including during a later burst.
- R10: After reset, chip select, shift clock, the data line towards the memory, `busy_o`, `done_o` and `mac_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a 16-word read burst (ignored while busy) |
| ee_cs_o | output | 1 | Memory chip select, active high |
| ee_sk_o | output | 1 | Memory shift clock |
| ee_di_o | output | 1 | Serial data towards the memory |
| ee_do_i | input | 1 | Serial data from the memory |
| busy_o | output | 1 | Burst in progress |
| done_o | output | 1 | One-cycle pulse when mac_o is updated |
| mac_o | output | 48 | Station address, image byte 20 in bits 47:40 |

## Verification
A wrong sequencer state shows up on the memory pins within one shift-clock phase. It appears as a command bit out of order, as data moving while the clock is high, or as chip select dropping before the 16th data bit. A behavioural memory in the bench catches each of these on the edge where it occurs. A wrong word index or byte lane only appears at the end of the burst, as a wrong `mac_o` value or as a repeated or skipped address seen by the memory model. A start that wrongly restarts a running burst shows up as an address sequence that falls back to zero.

// File: rtl/ee_pkg.sv
package ee_pkg;
  localparam logic [1:0] LEAD_BITS = 2'b00;
  localparam logic [2:0] OPC_READ  = 3'b110;
  localparam int unsigned WORD_W   = 16;

  typedef enum logic [3:0] {
    E_IDLE, E_CS_OFF, E_CS_ON, E_CMD_LO, E_CMD_HI,
    E_GAP, E_DAT_HI, E_DAT_LO, E_FINISH
  } eng_state_e;

  typedef enum logic [1:0] {C_IDLE, C_RUN, C_DONE} ctl_state_e;
endpackage

// File: rtl/ee_phase_tick.sv
module ee_phase_tick #(
  parameter int unsigned HALF_CYC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int unsigned CW = $clog2(HALF_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!en_i || tick_o)   cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/ee_word_engine.sv
module ee_word_engine
  import ee_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              do_i,
  output logic              active_o,
  output logic              cs_o,
  output logic              sk_o,
  output logic              di_o,
  output logic              word_v_o,
  output logic [WORD_W-1:0] word_o
);
  localparam int unsigned CMD_W = 5 + ADDR_W;
  localparam int unsigned BC_W  = $clog2((CMD_W > WORD_W ? CMD_W : WORD_W) + 1);

  eng_state_e        st_q;
  logic [BC_W-1:0]   bitc_q;
  logic [CMD_W-1:0]  cmd_q;
  logic [WORD_W-1:0] sh_q;
  logic              wv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= E_IDLE; bitc_q <= '0; cmd_q <= '0; sh_q <= '0; wv_q <= 1'b0;
    end else begin
      wv_q <= 1'b0;
      if (st_q == E_IDLE) begin
        if (req_i) begin
          st_q  <= E_CS_OFF;
          cmd_q <= {LEAD_BITS, OPC_READ, addr_i};
        end
      end else if (tick_i) begin
        case (st_q)
          E_CS_OFF: st_q <= E_CS_ON;
          E_CS_ON: begin
            st_q <= E_CMD_LO; bitc_q <= BC_W'(CMD_W - 1);
          end
          E_CMD_LO: st_q <= E_CMD_HI;
          E_CMD_HI:
            if (bitc_q == '0) st_q <= E_GAP;
            else begin bitc_q <= bitc_q - 1'b1; st_q <= E_CMD_LO; end
          E_GAP: begin
            st_q <= E_DAT_HI; bitc_q <= BC_W'(WORD_W - 1);
          end
          E_DAT_HI: begin
            sh_q <= {sh_q[WORD_W-2:0], do_i}; // sample at end of high phase
            st_q <= E_DAT_LO;
          end
          E_DAT_LO:
            if (bitc_q == '0) st_q <= E_FINISH;
            else begin bitc_q <= bitc_q - 1'b1; st_q <= E_DAT_HI; end
          E_FINISH: begin st_q <= E_IDLE; wv_q <= 1'b1; end
          default: st_q <= E_IDLE;
        endcase
      end
    end
  end

  logic in_cmd;
  assign in_cmd   = (st_q == E_CMD_LO) || (st_q == E_CMD_HI);
  assign active_o = (st_q != E_IDLE);
  assign cs_o     = (st_q != E_IDLE) && (st_q != E_CS_OFF) && (st_q != E_FINISH);
  assign sk_o     = (st_q == E_CMD_HI) || (st_q == E_DAT_HI);
  assign di_o     = in_cmd && cmd_q[bitc_q];
  assign word_v_o = wv_q;
  assign word_o   = sh_q;
endmodule

// File: rtl/ee_burst_ctrl.sv
module ee_burst_ctrl
  import ee_pkg::*;
#(
  parameter int unsigned ADDR_W    = 6,
  parameter int unsigned N_WORDS   = 16,
  parameter int unsigned MAC_OFS   = 20,
  parameter int unsigned MAC_BYTES = 6
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic                   word_v_i,
  input  logic [WORD_W-1:0]      word_i,
  output logic                   req_o,
  output logic [ADDR_W-1:0]      addr_o,
  output logic                   busy_o,
  output logic                   done_o,
  output logic [8*MAC_BYTES-1:0] mac_o
);
  localparam int unsigned N_BYTES = 2 * N_WORDS;
  localparam int unsigned WW      = $clog2(N_WORDS);
  localparam logic [WW-1:0] LAST_W = WW'(N_WORDS - 1);

  ctl_state_e             st_q;
  logic [WW-1:0]          widx_q;
  logic [7:0]             img_q [N_BYTES];
  logic                   req_q, done_q;
  logic [8*MAC_BYTES-1:0] mac_q, mac_d;

  always_comb begin
    for (int k = 0; k < MAC_BYTES; k++)
      mac_d[8*(MAC_BYTES-1-k) +: 8] = img_q[MAC_OFS + k];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= C_IDLE; widx_q <= '0; req_q <= 1'b0; done_q <= 1'b0; mac_q <= '0;
      for (int b = 0; b < N_BYTES; b++) img_q[b] <= '0;
    end else begin
      req_q  <= 1'b0;
      done_q <= 1'b0;
      case (st_q)
        C_IDLE:
          if (start_i) begin st_q <= C_RUN; widx_q <= '0; req_q <= 1'b1; end
        C_RUN:
          if (word_v_i) begin
            img_q[{widx_q, 1'b0}] <= word_i[7:0];
            img_q[{widx_q, 1'b1}] <= word_i[15:8];
            if (widx_q == LAST_W) st_q <= C_DONE;
            else begin widx_q <= widx_q + 1'b1; req_q <= 1'b1; end
          end
        C_DONE: begin
          done_q <= 1'b1; mac_q <= mac_d; st_q <= C_IDLE;
        end
        default: st_q <= C_IDLE;
      endcase
    end
  end

  assign req_o  = req_q;
  assign addr_o = ADDR_W'(widx_q);
  assign busy_o = (st_q != C_IDLE);
  assign done_o = done_q;
  assign mac_o  = mac_q;
endmodule

// File: rtl/ee_mac_reader.sv
module ee_mac_reader
  import ee_pkg::*;
#(
  parameter int unsigned HALF_CYC = 2,
  parameter int unsigned ADDR_W   = 6,
  parameter int unsigned N_WORDS  = 16,
  parameter int unsigned MAC_OFS  = 20
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  output logic        ee_cs_o,
  output logic        ee_sk_o,
  output logic        ee_di_o,
  input  logic        ee_do_i,
  output logic        busy_o,
  output logic        done_o,
  output logic [47:0] mac_o
);
  logic              tick, eng_active, req, word_v;
  logic [ADDR_W-1:0] addr;
  logic [WORD_W-1:0] word;

  ee_phase_tick #(.HALF_CYC(HALF_CYC)) u_tick (
    .clk_i, .rst_ni, .en_i(eng_active), .tick_o(tick)
  );

  ee_word_engine #(.ADDR_W(ADDR_W)) u_eng (
    .clk_i, .rst_ni, .tick_i(tick), .req_i(req), .addr_i(addr),
    .do_i(ee_do_i), .active_o(eng_active), .cs_o(ee_cs_o),
    .sk_o(ee_sk_o), .di_o(ee_di_o), .word_v_o(word_v), .word_o(word)
  );

  ee_burst_ctrl #(
    .ADDR_W(ADDR_W), .N_WORDS(N_WORDS), .MAC_OFS(MAC_OFS), .MAC_BYTES(6)
  ) u_ctl (
    .clk_i, .rst_ni, .start_i, .word_v_i(word_v), .word_i(word),
    .req_o(req), .addr_o(addr), .busy_o, .done_o, .mac_o
  );
endmodule

// File: rtl/ee_mac_reader_chk.sv
module ee_mac_reader_chk #(
  parameter int unsigned HALF_CYC = 2
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        start_i,
  input logic        ee_cs_o,
  input logic        ee_sk_o,
  input logic        ee_di_o,
  input logic        ee_do_i,
  input logic        busy_o,
  input logic        done_o,
  input logic [47:0] mac_o
);
  logic        sk_q;
  logic [15:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sk_q <= 1'b0; run_q <= 16'(HALF_CYC);
    end else begin
      sk_q <= ee_sk_o;
      if (ee_sk_o != sk_q)     run_q <= 16'd1;
      else if (run_q != '1)    run_q <= run_q + 16'd1;
    end
  end

  assert_sk_in_cs_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ee_sk_o |-> ee_cs_o);

  assert_di_held_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ee_sk_o |-> $stable(ee_di_o));

  assert_phase_len_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ee_sk_o != sk_q) |-> (run_q >= 16'(HALF_CYC)));

  assert_start_taken_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);

  assert_done_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_mac_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(mac_o));

  logic unused_ok;
  assign unused_ok = ee_do_i;
endmodule

bind ee_mac_reader ee_mac_reader_chk #(.HALF_CYC(HALF_CYC)) u_chk (.*);

// File: tb/tb_ee_mac_reader.sv
`timescale 1ns/1ps
module tb_ee_mac_reader;
  localparam int HALF = 2;

  logic clk_i = 1'b0, rst_ni = 1'b0, start_i = 1'b0, ee_do_i = 1'b0;
  logic ee_cs_o, ee_sk_o, ee_di_o, busy_o, done_o;
  logic [47:0] mac_o;

  always #10 clk_i = ~clk_i;

  ee_mac_reader #(.HALF_CYC(HALF)) dut (
    .clk_i, .rst_ni, .start_i, .ee_cs_o, .ee_sk_o, .ee_di_o, .ee_do_i,
    .busy_o, .done_o, .mac_o
  );

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory model
  logic [15:0] mem [16];
  logic [10:0] cmd_sr;
  int ncmd, nd, words_seen, exp_addr;
  int err_cmd, err_order, err_cs, err_di;
  bit tx_phase, active;
  logic [15:0] cur_word;

  always @(posedge ee_sk_o or negedge ee_cs_o) begin
    if (!ee_cs_o) begin
      if (active) begin
        if (!(tx_phase && nd == 16)) err_cs++;
        else words_seen++;
      end
      active = 0; tx_phase = 0; ncmd = 0; nd = 0; ee_do_i = 1'b0;
    end else begin
      active = 1;
      if (!tx_phase) begin
        cmd_sr = {cmd_sr[9:0], ee_di_o};
        ncmd++;
        if (ncmd == 11) begin
          if (cmd_sr[10:6] != 5'b00110) err_cmd++;
          if (int'(cmd_sr[5:0]) != exp_addr) err_order++;
          exp_addr++;
          cur_word = mem[cmd_sr[3:0]];
          tx_phase = 1; nd = 0;
        end
      end else begin
        if (ee_di_o !== 1'b0) err_di++;
        if (nd < 16) ee_do_i = cur_word[15 - nd];
        nd++;
      end
    end
  end

  // pin timing monitor
  logic sk_p = 1'b0, di_p = 1'b0;
  int run = 1000, min_run = 1000, err_setup = 0;
  always @(negedge clk_i) begin
    if (ee_sk_o && !sk_p && ee_di_o != di_p) err_setup++;
    if (ee_sk_o == sk_p) run++;
    else begin
      if (run < min_run) min_run = run;
      run = 1;
    end
    sk_p = ee_sk_o; di_p = ee_di_o;
  end

  function automatic logic [47:0] exp_mac();
    return {mem[10][7:0], mem[10][15:8], mem[11][7:0],
            mem[11][15:8], mem[12][7:0], mem[12][15:8]};
  endfunction

  task automatic clear_model();
    exp_addr = 0; words_seen = 0; err_cmd = 0; err_order = 0;
    err_cs = 0; err_di = 0; err_setup = 0; min_run = 1000;
  endtask

  task automatic pulse_start();
    @(negedge clk_i) start_i = 1'b1;
    @(negedge clk_i) start_i = 1'b0;
  endtask

  task automatic wait_done(output int cyc);
    cyc = 0;
    while (!done_o && cyc < 5000) begin @(negedge clk_i); cyc++; end
  endtask

  task automatic check_burst(input string tag);
    chk(err_cmd == 0, {"R1 command bits ", tag}, 64'(err_cmd), 0);
    chk(err_cs == 0, {"R2 chip select framing ", tag}, 64'(err_cs), 0);
    chk(err_setup == 0, {"R3 data change at clock rise ", tag}, 64'(err_setup), 0);
    chk(err_di == 0, {"R4 data line low while reading ", tag}, 64'(err_di), 0);
    chk(err_order == 0 && words_seen == 16, {"R5 address order ", tag},
        64'(words_seen), 16);
    chk(min_run >= HALF, {"R7 phase length ", tag}, 64'(min_run), 64'(HALF));
  endtask

  task automatic t_reset();
    chk(ee_cs_o == 0 && ee_sk_o == 0 && ee_di_o == 0, "R10 pins idle",
        64'({ee_cs_o, ee_sk_o, ee_di_o}), 0);
    chk(busy_o == 0 && done_o == 0, "R10 flags", 64'({busy_o, done_o}), 0);
    chk(mac_o == 48'h0, "R10 mac", 64'(mac_o), 0);
  endtask

  task automatic t_burst(input string tag);
    int cyc;
    clear_model();
    pulse_start();
    chk(busy_o == 1'b1, {"R8 busy after start ", tag}, 64'(busy_o), 1);
    wait_done(cyc);
    chk(done_o == 1'b1, {"R9 done seen ", tag}, 64'(done_o), 1);
    chk(busy_o == 1'b0, {"R8 idle at done ", tag}, 64'(busy_o), 0);
    chk(mac_o == exp_mac(), {"R6 mac value ", tag}, 64'(mac_o), 64'(exp_mac()));
    @(negedge clk_i);
    chk(done_o == 1'b0, {"R9 done one cycle ", tag}, 64'(done_o), 0);
    check_burst(tag);
  endtask

  task automatic t_start_ignored();
    int cyc;
    logic [47:0] m;
    for (int i = 0; i < 16; i++) mem[i] = 16'(i * 16'h0F1E + 16'h3C5A);
    clear_model();
    pulse_start();
    repeat (900) @(negedge clk_i);
    pulse_start();
    chk(busy_o == 1'b1, "R8 busy after stray start", 64'(busy_o), 1);
    wait_done(cyc);
    m = exp_mac();
    chk(mac_o == m, "R6 mac after stray start", 64'(mac_o), 64'(m));
    @(negedge clk_i);
    check_burst("stray");
  endtask

  task automatic t_mac_hold();
    logic [47:0] old;
    int cyc;
    old = mac_o;
    for (int i = 0; i < 16; i++) mem[i] = ~mem[i];
    repeat (20) @(negedge clk_i);
    chk(mac_o == old, "R9 mac held when idle", 64'(mac_o), 64'(old));
    clear_model();
    pulse_start();
    repeat (1500) @(negedge clk_i);
    chk(mac_o == old && busy_o, "R9 mac held during burst", 64'(mac_o), 64'(old));
    wait_done(cyc);
    chk(mac_o == exp_mac(), "R6 mac after refresh", 64'(mac_o), 64'(exp_mac()));
    @(negedge clk_i);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 16'(i * 16'h0123 + 16'h04D2);
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    t_reset();
    t_burst("ramp");
    for (int i = 0; i < 16; i++) mem[i] = 16'hFFFF;
    t_burst("ones");
    for (int i = 0; i < 16; i++) mem[i] = (i % 2 == 1) ? 16'h5AA5 : 16'hC33C;
    mem[10] = 16'h1100; mem[11] = 16'h3322; mem[12] = 16'h5544;
    t_burst("lanes");
    t_start_ignored();
    t_mac_hold();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule